// File: doc/BRIEF.md
# Status and Write-Protect Controller

This block keeps the eight-bit status byte of a serial nonvolatile memory and decides whether a write may start. The byte holds a busy flag, a write-enable latch, a two-bit protection level and a status-lock bit. The serial command engine sends one-cycle pulses when a command frame completes. These cover set-enable, clear-enable, page-write request (with its target address) and status-write request (with its data byte). The page buffer sends a one-cycle done pulse when its self-timed programming cycle ends.

For every request the block checks three things: the enable latch, the busy flag, and either the protected region (for page writes) or the lock formed by the status-lock bit and the write-protect pin (for status writes). An accepted request gives a one-cycle go pulse and sets busy. A refused request leaves all state as it was. A status write is self-timed like a page write. Its new protection and lock bits take effect when the done pulse arrives.

The protection and lock bits stand in for nonvolatile cells. A soft reset does not touch them. Power-on reset loads them from parameters.

Top module: `sts_guard`

## Requirements
- R1: `status_o` packs busy in bit 0, the write-enable latch in bit 1, protection level bit 0 in bit 2, protection level bit 1 in bit 3, and the status-lock bit in bit 7. Bits 6 to 4 always read 0.
- R2: While `por` is high at a clock edge, busy and the enable latch clear, and the protection level and lock bit load `DEF_LEVEL` and `DEF_LOCK` (default 0 and 0).
- R3: A soft reset `rst` clears busy, the enable latch and any write in flight, and keeps the protection level and lock bit.
- R4: `cmd_wren_i` sets the enable latch and `cmd_wrdi_i` clears it, one cycle after the pulse.
- R5: The protection level selects the protected addresses. Level 0 protects nothing, level 1 protects the top quarter (C000h to FFFFh), level 2 protects the top half (8000h to FFFFh), and level 3 protects the whole array.
- R6: `pw_ok_o` is high exactly when the enable latch is set, busy is clear and `pw_addr_i` lies outside the protected range. A request with `pw_ok_o` high pulses `pw_go_o` in the same cycle and sets busy one cycle later.
- R7: A refused page or status request changes neither the enable latch nor busy, and gives no go pulse.
- R8: A status write requires the enable latch set and busy clear. It is refused when the lock bit is 1 and `wp_i` is low. With `wp_i` high it is allowed whatever the lock bit holds.
- R9: An accepted status write copies only `sw_data_i` bit 7 (lock) and bits 3:2 (level). The new values appear one cycle after the done pulse, and the old values hold until then.
- R10: A `nvm_done_i` pulse while busy clears busy and the enable latch one cycle later. A done pulse while idle has no effect. If done and set-enable arrive in the same cycle, the latch ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| wp_i | input | 1 | Write-protect pin level (low asserts protection) |
| cmd_wren_i | input | 1 | Set-enable command completed |
| cmd_wrdi_i | input | 1 | Clear-enable command completed |
| pw_req_i | input | 1 | Page-write frame completed |
| pw_addr_i | input | ADDR_W | Page-write target address |
| sw_req_i | input | 1 | Status-write frame completed |
| sw_data_i | input | 8 | Status-write data byte |
| nvm_done_i | input | 1 | Self-timed write cycle finished |
| status_o | output | 8 | Status byte |
| pw_ok_o | output | 1 | Page write currently permitted for `pw_addr_i` |
| sw_ok_o | output | 1 | Status write currently permitted |
| pw_go_o | output | 1 | Page write accepted (start programming) |
| sw_go_o | output | 1 | Status write accepted (start programming) |

## Verification
The hardest state to reach is a status write that the lock refuses. Getting there takes a first status write with `wp_i` high that sets the lock bit, and the done pulse that commits it. Then the enable latch must be set again and `wp_i` lowered. The bench drives that exact chain as a directed case. It also sets each protection level this way before sweeping the region boundaries. After that, random traffic mixes all command pulses, pin changes and done pulses, so that refusals also occur while busy and in the middle of a write.

// File: rtl/sts_pkg.sv
package sts_pkg;

    // Nonvolatile part of the status byte
    typedef struct packed {
        logic       lock;
        logic [1:0] level;
    } nv_t;

    typedef enum logic {
        WK_PAGE = 1'b0,
        WK_STAT = 1'b1
    } wkind_e;

    localparam int STS_W = 8;

    // Protection test on the two most significant address bits
    function automatic logic level_hits(input logic [1:0] level, input logic [1:0] top2);
        logic hit;
        case (level)
            2'd0:    hit = 1'b0;
            2'd1:    hit = (top2 == 2'b11);
            2'd2:    hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic nv_t nv_from_byte(input logic [7:0] b);
        nv_t n;
        n.lock  = b[7];
        n.level = b[3:2];
        return n;
    endfunction

    function automatic logic [STS_W-1:0] pack_status(input nv_t nv, input logic wel, input logic busy);
        return {nv.lock, 3'b000, nv.level, wel, busy};
    endfunction

endpackage

// File: rtl/sts_region_dec.sv
module sts_region_dec
    import sts_pkg::*;
(
    input  logic [1:0] level_i,
    input  logic [1:0] top2_i,
    output logic       hit_o
);
    always_comb hit_o = level_hits(level_i, top2_i);
endmodule

// File: rtl/sts_wel_latch.sv
module sts_wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic set_i,
    input  logic clr_i,
    input  logic end_i,
    output logic wel_o
);
    logic wel_q;

    always_ff @(posedge clk) begin
        if (por || rst)   wel_q <= 1'b0;
        else if (end_i)   wel_q <= 1'b0;
        else if (clr_i)   wel_q <= 1'b0;
        else if (set_i)   wel_q <= 1'b1;
    end

    assign wel_o = wel_q;
endmodule

// File: rtl/sts_nv_bits.sv
module sts_nv_bits
    import sts_pkg::*;
#(
    parameter logic [1:0] DEF_LEVEL = 2'b00,
    parameter logic       DEF_LOCK  = 1'b0
) (
    input  logic clk,
    input  logic por,
    input  logic load_i,
    input  nv_t  val_i,
    output nv_t  nv_o
);
    nv_t nv_q;

    always_ff @(posedge clk) begin
        if (por)         nv_q <= '{lock: DEF_LOCK, level: DEF_LEVEL};
        else if (load_i) nv_q <= val_i;
    end

    assign nv_o = nv_q;
endmodule

// File: rtl/sts_wr_tracker.sv
module sts_wr_tracker
    import sts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   por,
    input  logic   go_i,
    input  wkind_e kind_i,
    input  nv_t    pend_i,
    input  logic   done_i,
    output logic   busy_o,
    output logic   fin_o,
    output logic   fin_stat_o,
    output nv_t    pend_o
);
    logic   busy_q;
    wkind_e kind_q;
    nv_t    pend_q;

    always_ff @(posedge clk) begin
        if (por || rst) begin
            busy_q <= 1'b0;
            kind_q <= WK_PAGE;
            pend_q <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            kind_q <= kind_i;
            pend_q <= pend_i;
        end else if (done_i && busy_q) begin
            busy_q <= 1'b0;
        end
    end

    assign busy_o     = busy_q;
    assign fin_o      = done_i && busy_q;
    assign fin_stat_o = fin_o && (kind_q == WK_STAT);
    assign pend_o     = pend_q;
endmodule

// File: rtl/sts_guard.sv
module sts_guard
    import sts_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter logic [1:0] DEF_LEVEL = 2'b00,
    parameter logic       DEF_LOCK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wp_i,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              pw_req_i,
    input  logic [ADDR_W-1:0] pw_addr_i,
    input  logic              sw_req_i,
    input  logic [7:0]        sw_data_i,
    input  logic              nvm_done_i,
    output logic [7:0]        status_o,
    output logic              pw_ok_o,
    output logic              sw_ok_o,
    output logic              pw_go_o,
    output logic              sw_go_o
);
    localparam int TOP_LSB = ADDR_W - 2;

    nv_t    nv, pend;
    logic   wel, busy, fin, fin_stat, hit, go;
    wkind_e kind;

    logic unused_bits;
    assign unused_bits = ^{sw_data_i[6:4], sw_data_i[1:0], pw_addr_i[TOP_LSB-1:0]};

    sts_region_dec u_dec (
        .level_i (nv.level),
        .top2_i  (pw_addr_i[ADDR_W-1:TOP_LSB]),
        .hit_o   (hit)
    );

    always_comb begin
        pw_ok_o = wel && !busy && !hit;
        sw_ok_o = wel && !busy && !(nv.lock && !wp_i);
        pw_go_o = pw_req_i && pw_ok_o;
        sw_go_o = sw_req_i && sw_ok_o && !pw_req_i;
        go      = pw_go_o || sw_go_o;
        kind    = sw_go_o ? WK_STAT : WK_PAGE;
    end

    sts_wr_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .por        (por),
        .go_i       (go),
        .kind_i     (kind),
        .pend_i     (nv_from_byte(sw_data_i)),
        .done_i     (nvm_done_i),
        .busy_o     (busy),
        .fin_o      (fin),
        .fin_stat_o (fin_stat),
        .pend_o     (pend)
    );

    sts_wel_latch u_wel (
        .clk   (clk),
        .rst   (rst),
        .por   (por),
        .set_i (cmd_wren_i),
        .clr_i (cmd_wrdi_i),
        .end_i (fin),
        .wel_o (wel)
    );

    sts_nv_bits #(
        .DEF_LEVEL (DEF_LEVEL),
        .DEF_LOCK  (DEF_LOCK)
    ) u_nv (
        .clk    (clk),
        .por    (por),
        .load_i (fin_stat),
        .val_i  (pend),
        .nv_o   (nv)
    );

    assign status_o = pack_status(nv, wel, busy);
endmodule

// File: rtl/sts_guard_chk.sv
module sts_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       wp_i,
    input logic       cmd_wren_i,
    input logic       cmd_wrdi_i,
    input logic       pw_req_i,
    input logic       sw_req_i,
    input logic       nvm_done_i,
    input logic [7:0] status_o,
    input logic       pw_go_o,
    input logic       sw_go_o
);
    // R6: acceptance only with latch set and not busy
    a_r6_go_needs_wel: assert property (@(posedge clk) disable iff (por || rst)
        pw_go_o |-> (status_o[1] && !status_o[0]));

    // R6: accepted write raises busy
    a_r6_go_sets_busy: assert property (@(posedge clk) disable iff (por || rst)
        pw_go_o |=> status_o[0]);

    // R10: done while busy ends the write and drops the latch
    a_r10_done_clears: assert property (@(posedge clk) disable iff (por || rst)
        (nvm_done_i && status_o[0]) |=> (!status_o[0] && !status_o[1]));

    // R8: lock bit with pin low refuses status writes
    a_r8_locked: assert property (@(posedge clk) disable iff (por || rst)
        (sw_req_i && status_o[7] && !wp_i) |-> !sw_go_o);

    // R7: refused page request keeps the latch
    a_r7_reject_keeps_wel: assert property (@(posedge clk) disable iff (por || rst)
        (pw_req_i && !pw_go_o && !nvm_done_i && !cmd_wren_i && !cmd_wrdi_i)
        |=> $stable(status_o[1]));

    // R9: level and lock bits only move on a finishing write
    a_r9_nv_stable: assert property (@(posedge clk) disable iff (por)
        !(nvm_done_i && status_o[0]) |=> $stable({status_o[7], status_o[3:2]}));

    // R4: set-enable takes effect unless a write finishes
    a_r4_wren_sets: assert property (@(posedge clk) disable iff (por || rst)
        (cmd_wren_i && !nvm_done_i) |=> status_o[1]);
endmodule

bind sts_guard sts_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .wp_i       (wp_i),
    .cmd_wren_i (cmd_wren_i),
    .cmd_wrdi_i (cmd_wrdi_i),
    .pw_req_i   (pw_req_i),
    .sw_req_i   (sw_req_i),
    .nvm_done_i (nvm_done_i),
    .status_o   (status_o),
    .pw_go_o    (pw_go_o),
    .sw_go_o    (sw_go_o)
);

// File: tb/sts_guard_bench.sv
`timescale 1ns/1ps
module sts_guard_bench;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst, por, wp, wren, wrdi, pwreq, swreq, done;
    logic [AW-1:0] addr;
    logic [7:0]    sdata;
    logic [7:0]    status;
    logic          pw_ok, sw_ok, pw_go, sw_go;

    sts_guard u_sts_guard (
        .clk(clk), .rst(rst), .por(por), .wp_i(wp),
        .cmd_wren_i(wren), .cmd_wrdi_i(wrdi),
        .pw_req_i(pwreq), .pw_addr_i(addr),
        .sw_req_i(swreq), .sw_data_i(sdata), .nvm_done_i(done),
        .status_o(status), .pw_ok_o(pw_ok), .sw_ok_o(sw_ok),
        .pw_go_o(pw_go), .sw_go_o(sw_go)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    // reference model state
    logic       m_busy, m_wel, m_lock, m_kstat, m_plock;
    logic [1:0] m_level, m_plevel;

    function automatic logic prot_ref(input logic [1:0] lv, input logic [AW-1:0] a);
        return (lv == 2'd3) || (lv == 2'd2 && a >= 16'h8000) || (lv == 2'd1 && a >= 16'hC000);
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_level, m_wel, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input logic i_por, input logic i_rst,
                       input logic i_wren, input logic i_wrdi,
                       input logic i_pw, input logic [AW-1:0] i_addr,
                       input logic i_sw, input logic [7:0] i_data, input logic i_done);
        logic e_pwok, e_swok, e_pwgo, e_swgo, fin;
        @(negedge clk);
        por = i_por; rst = i_rst; wren = i_wren; wrdi = i_wrdi;
        pwreq = i_pw; addr = i_addr; swreq = i_sw; sdata = i_data; done = i_done;
        #1;
        if (!i_por && !i_rst) begin
            e_pwok = m_wel && !m_busy && !prot_ref(m_level, i_addr);
            e_swok = m_wel && !m_busy && (wp || !m_lock);
            e_pwgo = i_pw && e_pwok;
            e_swgo = i_sw && e_swok && !i_pw;
            chk({tag, " R6 pw_ok"}, {7'd0, pw_ok}, {7'd0, e_pwok});
            chk({tag, " R8 sw_ok"}, {7'd0, sw_ok}, {7'd0, e_swok});
            chk({tag, " R6/R7 go"}, {6'd0, pw_go, sw_go}, {6'd0, e_pwgo, e_swgo});
            fin = i_done && m_busy;
            if (fin && m_kstat) begin m_lock = m_plock; m_level = m_plevel; end
            if (fin) m_wel = 0; else if (i_wrdi) m_wel = 0; else if (i_wren) m_wel = 1;
            if (e_pwgo || e_swgo) begin
                m_busy = 1; m_kstat = e_swgo; m_plock = i_data[7]; m_plevel = i_data[3:2];
            end else if (fin) m_busy = 0;
        end else begin
            m_busy = 0; m_wel = 0; m_kstat = 0;
            if (i_por) begin m_lock = 1'b0; m_level = 2'b00; end
        end
        @(posedge clk); #1;
        chk({tag, " R1 status"}, status, exp_status());
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, '0, 0, 8'h00, 0);
    endtask
    task automatic do_wren(input string tag);
        cyc(tag, 0, 0, 1, 0, 0, '0, 0, 8'h00, 0);
    endtask
    task automatic do_done(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, '0, 0, 8'h00, 1);
    endtask
    task automatic set_nv(input logic [7:0] b);
        wp = 1;
        do_wren("R9 setup");
        cyc("R9 swrite", 0, 0, 0, 0, 0, '0, 1, b, 0);
        do_done("R10 setup done");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [AW-1:0] corners [6];
        seed = $urandom(32'h5EED_0042);
        corners = '{16'h0000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
        por = 1; rst = 0; wp = 1; wren = 0; wrdi = 0; pwreq = 0; swreq = 0; done = 0;
        addr = '0; sdata = '0;
        m_busy = 0; m_wel = 0; m_lock = 0; m_level = 0; m_kstat = 0; m_plock = 0; m_plevel = 0;

        // R2: power-on state
        cyc("R2 por", 1, 0, 0, 0, 0, '0, 0, 8'h00, 0);
        cyc("R2 por", 1, 0, 0, 0, 0, '0, 0, 8'h00, 0);
        chk("R2 por status", status, 8'h00);

        // R4: set and clear the latch
        do_wren("R4 wren");
        chk("R4 wel set", status, 8'h02);
        cyc("R4 wrdi", 0, 0, 0, 1, 0, '0, 0, 8'h00, 0);
        chk("R4 wel clr", status, 8'h00);

        // R7: page write without latch refused
        cyc("R7 no wel", 0, 0, 0, 0, 1, 16'h0000, 0, 8'h00, 0);
        chk("R7 no wel status", status, 8'h00);

        // R9/R1: status write with all ones, only lock and level land
        wp = 1;
        do_wren("R9 wren");
        cyc("R9 sw", 0, 0, 0, 0, 0, '0, 1, 8'hFF, 0);
        chk("R9 busy, old nv kept", status, 8'h03);
        idle("R9 hold");
        chk("R9 still old", status, 8'h03);
        do_done("R10 done");
        chk("R1 R9 committed", status, 8'h8C);

        // R8: locked with pin low
        do_wren("R8 wren");
        wp = 0;
        cyc("R8 locked", 0, 0, 0, 0, 0, '0, 1, 8'h00, 0);
        chk("R8 R7 refused keeps wel", status, 8'h8E);
        wp = 1;
        cyc("R8 pin high", 0, 0, 0, 0, 0, '0, 1, 8'h00, 0);
        do_done("R10 done");
        chk("R8 unlocked write", status, 8'h00);

        // R5: region sweep per level
        for (int lv = 0; lv < 4; lv++) begin
            set_nv({6'd0, lv[1:0]} << 2);
            do_wren("R5 wren");
            foreach (corners[k]) begin
                cyc("R5 sweep", 0, 0, 0, 0, 0, corners[k], 0, 8'h00, 0);
                chk("R5 region", {7'd0, pw_ok}, {7'd0, !prot_ref(lv[1:0], corners[k])});
            end
        end

        // R7/R6/R10 with level 1
        set_nv(8'h04);
        do_wren("R7 wren");
        cyc("R7 protected", 0, 0, 0, 0, 1, 16'hFFFF, 0, 8'h00, 0);
        chk("R7 keeps wel", status, 8'h06);
        cyc("R6 accepted", 0, 0, 0, 0, 1, 16'h1234, 0, 8'h00, 0);
        chk("R6 busy", status, 8'h07);
        cyc("R6 busy req", 0, 0, 0, 0, 1, 16'h0000, 0, 8'h00, 0);
        chk("R6 busy refused", {7'd0, pw_go}, 8'h00);
        cyc("R10 done+wren", 0, 0, 1, 0, 0, '0, 0, 8'h00, 1);
        chk("R10 done wins", status, 8'h04);
        do_done("R10 idle done");
        chk("R10 idle done", status, 8'h04);

        // R3: soft reset during a write
        do_wren("R3 wren");
        cyc("R3 start", 0, 0, 0, 0, 0, '0, 1, 8'h88, 0);
        cyc("R3 rst", 0, 1, 0, 0, 0, '0, 0, 8'h00, 0);
        chk("R3 rst keeps nv", status, 8'h04);
        do_done("R3 no pending");
        chk("R3 pending dropped", status, 8'h04);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [AW-1:0] a;
            r = $urandom % 16;
            a = AW'($urandom);
            if ($urandom % 2 == 0) a[AW-1:AW-2] = 2'b11;
            if (r == 12) wp = ~wp;
            case (r)
                0, 1, 2: do_wren("R4 rnd");
                3:       cyc("R4 rnd", 0, 0, 0, 1, 0, a, 0, 8'h00, 0);
                4, 5, 6: cyc("R6 rnd", 0, 0, 0, 0, 1, a, 0, 8'h00, 0);
                7, 8:    cyc("R9 rnd", 0, 0, 0, 0, 0, a, 1, 8'($urandom), 0);
                9, 10, 11: do_done("R10 rnd");
                13:      cyc("R3 rnd", 0, ($urandom % 8 == 0), 0, 0, 0, a, 0, 8'h00, 0);
                default: cyc("R5 rnd", 0, 0, 0, 0, 0, a, 0, 8'h00, 0);
            endcase
        end

        // R2: power-on after nonzero level
        set_nv(8'h8C);
        cyc("R2 por again", 1, 0, 0, 0, 0, '0, 0, 8'h00, 0);
        chk("R2 defaults", status, 8'h00);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule